// File: doc/BRIEF.md
# Three-Lane Frame Deserializer with Failsafe Outputs

This block sits behind three serial data receivers and one forwarded frame clock. A local bit clock runs at seven times the frame rate and is supplied as an input. In each frame the block collects seven bits from every lane and presents them as one 21-bit parallel word. It also produces a parallel output clock with a 50% duty cycle. The forwarded clock is sampled in the bit-clock domain. A frame starts at the bit-clock cycle in which the forwarded clock is first seen high.

The block watches its inputs for two faults. The first is loss of the forwarded clock, which it finds with an activity timeout. The second is loss of the data lanes, which arrives as a per-lane idle indication from the receivers. For each fault, and for the two faults together, the outputs follow a fixed policy. The policy for both faults depends on which fault came first. An active-low power-down input overrides everything and forces fixed output levels. Capture continues underneath power-down.

Top module: `frame_deser`

## Requirements
- R1: In the bit-clock cycle where the forwarded clock is first seen high, each lane carries bit 0 of the frame. The next six cycles carry bits 1 to 6. Lane k lands in output bits 7k+0 through 7k+6. All 21 output bits change together, one cycle after bit 6 is sampled.
- R2: While operating normally, the output clock has a period of seven bit clocks. It is high for exactly half of that period, 3.5 bit clocks.
- R3: While `pwr_dn_n` is low, `par_data` is all zeros and `par_clk` is high. When it returns high, the word captured most recently is shown.
- R4: When the forwarded clock is lost while the data lanes are active, `par_data` holds the last valid word and `par_clk` stays high.
- R5: When any `lane_idle` bit is high while the forwarded clock is active, `par_data` is all ones (0x1FFFFF) and `par_clk` keeps toggling. Words received during this time are discarded.
- R6: Clock loss is declared once 16 consecutive bit-clock cycles have passed without a rising edge of the forwarded clock. With 15 such cycles, loss is not declared.
- R7: When both faults are present and the clock was lost first, the last valid word is held. When the data was lost first, or both faults began in the same cycle, the output is all ones. In both cases `par_clk` is high.
- R8: After the forwarded clock returns, `par_clk` stays high and the held word stays on `par_data` until one complete frame has been received. That frame's word is then shown and the output clock resumes.
- R9: After reset, `par_data` is zero and `par_clk` is high until the first complete frame arrives.
- R10: A rising edge of the forwarded clock that arrives before bit 6 of the current frame restarts the frame. The partial frame is discarded and does not change the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local bit clock, seven times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down; forces the output levels |
| fwd_clk | input | 1 | Forwarded frame clock, sampled on `clk` |
| ser_in | input | 3 | One serial bit per lane per bit-clock cycle |
| lane_idle | input | 3 | Per-lane indication that the lane is undriven |
| par_data | output | 21 | Recovered parallel word |
| par_clk | output | 1 | Parallel output clock |

## Verification
Clock loss and data loss can both be present at the same time, and the outcome depends on their order. The bench provokes each order on purpose. In one case the forwarded clock is stopped for twenty bit clocks before a lane is marked idle. In the other case a lane is marked idle first and the clock is stopped afterwards. In each case the bench then checks for the held word or for all ones, and checks that the clock sits high. Finally it releases the lane and confirms that a clock-only fault now holds the word that was captured before the data loss.

// File: rtl/frame_deser.sv
module frame_deser #(
  parameter int LANES       = 3,
  parameter int BITS        = 7,
  parameter int LOSS_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_dn_n,
  input  logic                   fwd_clk,
  input  logic [LANES-1:0]       ser_in,
  input  logic [LANES-1:0]       lane_idle,
  output logic [LANES*BITS-1:0]  par_data,
  output logic                   par_clk
);
  localparam int W    = LANES * BITS;
  localparam int CW   = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int IW   = $clog2(LOSS_CYCLES + 1);
  localparam int HALF = (BITS + 1) / 2;

  logic          fwd_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] idx;
  logic          framed_q;
  logic [W-1:0]  cap_q;
  logic [W-1:0]  cap_d;
  logic [W-1:0]  word_q;
  logic [IW-1:0] idle_q;
  logic          resync_q;
  logic          data_bad;
  logic          clk_first_q;
  logic          run_a;
  logic          run_clk;
  logic          rise;
  logic          frame_done;
  logic          clk_lost;
  logic          clk_bad;
  logic          ones;

  assign rise       = fwd_clk & ~fwd_q;
  assign idx        = rise ? '0 : cnt_q;
  assign frame_done = (rise | framed_q) && (idx == CW'(BITS - 1));
  assign clk_lost   = (idle_q == IW'(LOSS_CYCLES));
  assign clk_bad    = clk_lost | resync_q;
  assign ones       = data_bad & ~(clk_bad & clk_first_q);

  always_comb begin
    cap_d = cap_q;
    for (int k = 0; k < LANES; k++)
      cap_d[k*BITS + int'(idx)] = ser_in[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_q       <= 1'b0;
      cnt_q       <= '0;
      framed_q    <= 1'b0;
      cap_q       <= '0;
      word_q      <= '0;
      idle_q      <= IW'(LOSS_CYCLES);
      resync_q    <= 1'b1;
      data_bad    <= 1'b0;
      clk_first_q <= 1'b0;
      run_a       <= 1'b0;
    end else begin
      fwd_q    <= fwd_clk;
      cnt_q    <= (idx == CW'(BITS - 1)) ? '0 : idx + CW'(1);
      framed_q <= (rise | framed_q) & ~frame_done;
      cap_q    <= cap_d;
      if (frame_done && !data_bad)
        word_q <= cap_d;
      if (rise)
        idle_q <= '0;
      else if (!clk_lost)
        idle_q <= idle_q + IW'(1);
      if (clk_lost)
        resync_q <= 1'b1;
      else if (frame_done)
        resync_q <= 1'b0;
      data_bad <= |lane_idle;
      if (!data_bad)
        clk_first_q <= clk_bad;
      run_a <= (idx < CW'(HALF));
    end
  end

  generate
    if (BITS % 2 == 1) begin : g_odd
      logic run_b;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) run_b <= 1'b0;
        else        run_b <= run_a;
      end
      assign run_clk = run_a & run_b;
    end else begin : g_even
      assign run_clk = run_a;
    end
  endgenerate

  assign par_data = !pwr_dn_n ? '0 : (ones ? '1 : word_q);
  assign par_clk  = !pwr_dn_n | clk_bad | run_clk;

endmodule

// File: rtl/frame_deser_chk.sv
module frame_deser_chk #(
  parameter int LOSS_CYCLES = 16,
  parameter int W           = 21
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_dn_n,
  input logic         fwd_clk,
  input logic [W-1:0] par_data,
  input logic         par_clk,
  input logic         clk_lost,
  input logic         clk_bad,
  input logic         data_bad
);
  localparam int CW = $clog2(LOSS_CYCLES + 1);

  logic          f_q;
  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q   <= 1'b0;
      gap_q <= CW'(LOSS_CYCLES);
    end else begin
      f_q <= fwd_clk;
      if (fwd_clk && !f_q)
        gap_q <= '0;
      else if (gap_q != CW'(LOSS_CYCLES))
        gap_q <= gap_q + CW'(1);
    end
  end

  p_pd_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn_n |-> (par_data == '0) && par_clk);

  p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn_n && $past(pwr_dn_n) && clk_bad && $past(clk_bad) && !data_bad && !$past(data_bad)
    |-> $stable(par_data) && par_clk);

  p_ones_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn_n && data_bad && !clk_bad |-> (&par_data));

  p_loss_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == CW'(LOSS_CYCLES)) |-> clk_lost);

  p_loss_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q < CW'(LOSS_CYCLES)) |-> !clk_lost);

  p_data_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn_n && data_bad && $past(data_bad) && clk_bad && !$past(clk_bad)
    |-> (&par_data) && par_clk);

endmodule

bind frame_deser frame_deser_chk #(.LOSS_CYCLES(LOSS_CYCLES), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .fwd_clk(fwd_clk),
  .par_data(par_data), .par_clk(par_clk), .clk_lost(clk_lost),
  .clk_bad(clk_bad), .data_bad(data_bad)
);

// File: tb/test_frame_deser.sv
`timescale 1ns/100ps
module test_frame_deser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_dn_n = 1'b1;
  logic        fwd_clk = 1'b0;
  logic [2:0]  ser_in = '0;
  logic [2:0]  lane_idle = '0;
  logic [20:0] par_data;
  logic        par_clk;

  int errors = 0;
  int checks = 0;
  int lows   = 0;
  int highs  = 0;
  logic [20:0] pend_w = '0;
  bit          pend_v = 1'b0;
  string       pend_req = "R1";

  localparam logic [20:0] ONES = 21'h1FFFFF;
  localparam logic [20:0] TBL [8] = '{
    21'h00007F, 21'h003F80, 21'h1FC000, 21'h155555,
    21'h0AAAAA, 21'h123456, 21'h000001, 21'h100000
  };

  always #10 clk = ~clk;

  frame_deser i_frame_deser (
    .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .fwd_clk(fwd_clk),
    .ser_in(ser_in), .lane_idle(lane_idle), .par_data(par_data), .par_clk(par_clk)
  );

  task automatic chk(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [20:0] w);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); #1;
      if (i == 0 && pend_v) chk(pend_req, par_data, pend_w);
      if (par_clk == 1'b0) lows++;
      fwd_clk = (i < 4);
      for (int k = 0; k < 3; k++) ser_in[k] = w[k*7 + i];
    end
    pend_w = w;
  endtask

  task automatic send_part(input logic [20:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      fwd_clk = (i < 2);
      for (int k = 0; k < 3; k++) ser_in[k] = w[k*7 + i];
    end
  endtask

  task automatic flush(input string req);
    @(negedge clk); #1;
    chk(req, par_data, pend_w);
  endtask

  task automatic idle_step();
    @(negedge clk); #1;
    if (par_clk == 1'b0) lows++;
    fwd_clk = 1'b0;
    ser_in  = ser_in ^ 3'b101;
  endtask

  task automatic measure();
    repeat (2) @(posedge clk);
    for (int c = 0; c < 7; c++) begin
      @(posedge clk);
      #2.5; if (par_clk) highs++;
      #5;   if (par_clk) highs++;
      #5;   if (par_clk) highs++;
      #5;   if (par_clk) highs++;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 during reset data", par_data, '0);
    chk("R9 during reset clk", {20'b0, par_clk}, 21'h1);
    rst_n = 1'b1;
    repeat (20) idle_step();
    chk("R9 no frame yet data", par_data, '0);
    chk("R9 no frame yet clk", {20'b0, par_clk}, 21'h1);

    // R1 table of frames; R2 duty measured during frames 3-4
    pend_req = "R1";
    for (int t = 0; t < 8; t++) begin
      if (t == 3) fork measure(); join_none
      send_frame(TBL[t]);
      pend_v = 1'b1;
    end
    flush("R1");
    chk("R2 high quarter-samples per 7 bit clocks", 21'(highs), 21'd14);
    pend_v = 1'b0;

    // R10 early edge discards partial frame
    send_part(21'h0F0F0F, 4);
    @(negedge clk); #1;
    chk("R10 partial frame ignored", par_data, TBL[7]);
    send_frame(21'h0ABCDE);
    flush("R10 frame after restart");

    // R6 / R4 / R8 clock loss and recovery
    send_frame(21'h13579B);
    lows = 0;
    for (int j = 1; j <= 10; j++) idle_step();
    chk("R6 no loss at 15 idle cycles (clock lows seen)", 21'(lows > 0), 21'd1);
    ok = 1'b1;
    for (int j = 11; j <= 25; j++) begin
      idle_step();
      if (par_clk !== 1'b1) ok = 1'b0;
    end
    chk("R6 loss declared, clock high", 21'(ok), 21'd1);
    chk("R4 last word held", par_data, 21'h13579B);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); #1;
      if (i == 6) begin
        chk("R8 clock still high mid-frame", {20'b0, par_clk}, 21'h1);
        chk("R8 word still held mid-frame", par_data, 21'h13579B);
      end
      fwd_clk = (i < 4);
      for (int k = 0; k < 3; k++) ser_in[k] = 21'h02468A >> (k*7 + i);
    end
    @(negedge clk); #1;
    chk("R8 new word after full frame", par_data, 21'h02468A);
    chk("R8 clock resumed", {20'b0, par_clk}, 21'h0);

    // R5 data loss with clock running
    send_frame(21'h111111);
    flush("R5 setup");
    lane_idle = 3'b010;
    lows = 0;
    send_frame(21'h0FFF00);
    chk("R5 outputs all ones", par_data, ONES);
    chk("R5 clock keeps running", 21'(lows > 0), 21'd1);
    send_frame(21'h0FFF00);
    lane_idle = 3'b000;
    send_frame(21'h0C3C3C);
    flush("R5 recovery word");

    // R7 clock lost first, then data
    send_frame(21'h055AA5);
    flush("R7 setup clock-first");
    repeat (20) idle_step();
    lane_idle = 3'b001;
    repeat (3) idle_step();
    chk("R7 clock-first holds word", par_data, 21'h055AA5);
    chk("R7 clock-first clock high", {20'b0, par_clk}, 21'h1);
    lane_idle = 3'b000;
    send_frame(21'h1E1E1E);
    flush("R7 recovery after clock-first");

    // R7 data lost first, then clock
    send_frame(21'h0DEAD1);
    flush("R7 setup data-first");
    lane_idle = 3'b100;
    repeat (3) idle_step();
    repeat (20) idle_step();
    chk("R7 data-first drives ones", par_data, ONES);
    chk("R7 data-first clock high", {20'b0, par_clk}, 21'h1);
    lane_idle = 3'b000;
    repeat (2) idle_step();
    chk("R7 clock-only after data returns holds word", par_data, 21'h0DEAD1);
    send_frame(21'h1BEEF0);
    flush("R7 recovery after data-first");

    // R3 power-down
    pwr_dn_n = 1'b0;
    #1;
    chk("R3 data low", par_data, '0);
    chk("R3 clock high", {20'b0, par_clk}, 21'h1);
    send_frame(21'h0F00F1);
    @(negedge clk); #1;
    chk("R3 data low while frames arrive", par_data, '0);
    repeat (20) idle_step();
    chk("R3 clock high during loss", {20'b0, par_clk}, 21'h1);
    pwr_dn_n = 1'b1;
    #1;
    chk("R3 release shows latest word", par_data, 21'h0F00F1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule